// File: doc/BRIEF.md
# Regulator Power-Good and Fault Supervisor

This block sits between the comparator bank of a core-voltage buck regulator and its switching controller. It takes single-bit comparator flags and turns them into four control outputs. A power-good flag tells the processor that the rail is usable. A run signal enables the converter. A force-on request pulls the low-side switch on as a crowbar. A soft-start restart holds the reference ramp at its start point.

The supervisor handles several conditions:
- Supply lockout with hysteresis, which also acts as the power-on reset.
- The enable pin.
- A power-good window around the programmed reference. This check is masked while the reference moves.
- An output undervoltage shutdown that latches.
- An overvoltage crowbar that releases by itself.
- Thermal shutdown. On release from thermal shutdown the converter restarts through a full soft-start.

Slow comparator flags pass through a short agreement filter before they take effect. The overvoltage flag bypasses this filter so the crowbar acts quickly.

Top module: `pg_fault_supervisor`

## Requirements
- R1: After reset the supply is treated as locked out: run=0, pg_ok=0, ls_force=0, ss_hold=1. Lockout releases only when the filtered rising-level flag is 1. Once released, lockout engages again only when the filtered falling-level flag is 0. While the supply sits between the two levels, the current state is kept.
- R2: A slow flag changes its filtered value only after it has held the new value for STAGES consecutive clock samples. A pulse of one clock on any slow flag has no effect on the outputs.
- R3: With the converter running, soft-start done and no reference move, pg_ok is 0 whenever the filtered above-window or below-window flag is 1, and 1 otherwise.
- R4: pg_ok is 0 whenever run is 0 or ss_done is 0.
- R5: While ref_moving is 1 and the converter runs with soft-start done, pg_ok is 1 whatever the window flags show.
- R6: When the filtered below-75% flag is 1, the converter runs, ss_done is 1 and ref_moving is 0, a fault latches and run falls. The check is ignored while ref_moving is 1.
- R7: ls_force follows out_ovp_raw one clock later. It falls as soon as the flag clears, and it never latches.
- R8: When the filtered over-temperature flag is 1, run goes 0. Run stays 0 until the filtered below-restart-temperature flag is 1. Between the two levels, shutdown persists.
- R9: oc_latched=1 latches a fault. Any latched fault keeps run=0 and pg_ok=0 until the filtered enable goes 0 or lockout engages. If a clear and a set happen in the same cycle, the clear wins.
- R10: ss_hold is 1 exactly when run is 0, so every restart begins a full soft-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_raw | input | 1 | Enable pin level |
| vcc_rise_raw | input | 1 | Supply above the release level |
| vcc_fall_raw | input | 1 | Supply above the lockout level |
| out_hi_raw | input | 1 | Output above the upper power-good level |
| out_lo_raw | input | 1 | Output below the lower power-good level |
| out_uv_raw | input | 1 | Output below 75% of the set value |
| out_ovp_raw | input | 1 | Output above the absolute overvoltage level |
| temp_hot_raw | input | 1 | Die above the shutdown temperature |
| temp_cool_raw | input | 1 | Die below the restart temperature |
| ss_done | input | 1 | Soft-start ramp has completed |
| ref_moving | input | 1 | Reference transition in progress |
| oc_latched | input | 1 | Overcurrent protection has latched |
| pg_ok | output | 1 | Power-good |
| run | output | 1 | Converter enable |
| ls_force | output | 1 | Force the low-side switch on |
| ss_hold | output | 1 | Hold soft-start at its start point |

## Verification
Two functions can land in the same cycle: the undervoltage trip and the reference-move mask. The bench raises the below-75% flag while ref_moving is already high, so both take effect together. It then requires run to stay high and pg_ok to stay high. When the move ends, it requires the latch to set.

A second collision is the overvoltage crowbar firing while power-good stays valid. Here the bench checks that ls_force rises without disturbing pg_ok or run.

// File: rtl/pg_fault_supervisor.sv
module pg_fault_supervisor #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_raw,
  input  logic vcc_rise_raw,
  input  logic vcc_fall_raw,
  input  logic out_hi_raw,
  input  logic out_lo_raw,
  input  logic out_uv_raw,
  input  logic out_ovp_raw,
  input  logic temp_hot_raw,
  input  logic temp_cool_raw,
  input  logic ss_done,
  input  logic ref_moving,
  input  logic oc_latched,
  output logic pg_ok,
  output logic run,
  output logic ls_force,
  output logic ss_hold
);
  localparam int NF = 8;
  localparam int EN = 7, VR = 6, VF = 5, HI = 4, LO = 3, UV = 2, HOT = 1, COOL = 0;

  logic [NF-1:0] raw, filt, filt_nx, all1, all0;
  logic [NF-1:0] sh [STAGES];
  logic locked, fault, hot;

  assign raw = {en_raw, vcc_rise_raw, vcc_fall_raw, out_hi_raw,
                out_lo_raw, out_uv_raw, temp_hot_raw, temp_cool_raw};

  always_comb begin
    all1 = '1;
    all0 = '1;
    for (int i = 0; i < STAGES; i++) begin
      all1 &= sh[i];
      all0 &= ~sh[i];
    end
    filt_nx = (filt & ~(all1 | all0)) | all1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) sh[i] <= '0;
      filt <= '0;
    end else begin
      sh[0] <= raw;
      for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
      filt <= filt_nx;
    end
  end

  logic clr, uv_trip;
  assign clr     = !filt[EN] || locked;
  assign uv_trip = filt[UV] && ss_done && !ref_moving && run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b1;
      fault    <= 1'b0;
      hot      <= 1'b0;
      ls_force <= 1'b0;
    end else begin
      locked   <= locked ? !filt[VR] : !filt[VF];
      fault    <= clr ? 1'b0 : (fault || uv_trip || oc_latched);
      hot      <= hot ? !filt[COOL] : filt[HOT];
      ls_force <= out_ovp_raw;
    end
  end

  assign run     = filt[EN] && !locked && !fault && !hot;
  assign ss_hold = !run;
  assign pg_ok   = run && ss_done && (ref_moving || !(filt[HI] || filt[LO]));
endmodule

module pg_fault_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic out_ovp_raw,
  input logic ss_done,
  input logic ref_moving,
  input logic oc_latched,
  input logic pg_ok,
  input logic run,
  input logic ls_force
);
  assert_crowbar_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovp_raw |=> ls_force);
  assert_crowbar_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ovp_raw |=> !ls_force);
  assert_pg_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pg_ok |-> (run && ss_done));
  assert_pg_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ss_done && ref_moving) |-> pg_ok);
  assert_oc_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oc_latched |=> !run);
endmodule

bind pg_fault_supervisor pg_fault_supervisor_chk i_chk (
  .clk(clk), .rst_n(rst_n), .out_ovp_raw(out_ovp_raw), .ss_done(ss_done),
  .ref_moving(ref_moving), .oc_latched(oc_latched), .pg_ok(pg_ok),
  .run(run), .ls_force(ls_force)
);

// File: tb/test_pg_fault_supervisor.sv
module test_pg_fault_supervisor;
  logic clk = 0, rst_n = 0;
  logic en, vr, vf, hi, lo, uv, ovp, th, tc, ssd, mov, oc;
  logic pg_ok, run, ls_force, ss_hold;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pg_fault_supervisor i_pg_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .en_raw(en), .vcc_rise_raw(vr), .vcc_fall_raw(vf),
    .out_hi_raw(hi), .out_lo_raw(lo), .out_uv_raw(uv), .out_ovp_raw(ovp),
    .temp_hot_raw(th), .temp_cool_raw(tc), .ss_done(ssd), .ref_moving(mov),
    .oc_latched(oc), .pg_ok(pg_ok), .run(run), .ls_force(ls_force), .ss_hold(ss_hold));

  // inputs {en,vr,vf,hi,lo,uv,ovp,hot,cool,ssd,mov,oc}, expected {pg_ok,run,ls_force,ss_hold}
  localparam logic [15:0] VEC [22] = '{
    {12'b1110_0000_1000, 4'b0100},  // R4 soft-start pending
    {12'b1110_0000_1100, 4'b1100},  // R3 in window
    {12'b1111_0000_1100, 4'b0100},  // R3 above window
    {12'b1111_0000_1110, 4'b1100},  // R5 masked during move
    {12'b1110_1100_1110, 4'b1100},  // R6 undervoltage ignored during move
    {12'b1110_1100_1100, 4'b0001},  // R6 latch after move ends
    {12'b1110_0000_1100, 4'b0001},  // R9 stays latched
    {12'b0110_0000_1100, 4'b0001},  // R9 enable low
    {12'b1110_0000_1100, 4'b1100},  // R9 cleared by toggle
    {12'b1110_0010_1100, 4'b1110},  // R7 crowbar
    {12'b1110_0000_1100, 4'b1100},  // R7 released
    {12'b1110_0001_0100, 4'b0001},  // R8 hot
    {12'b1110_0000_0100, 4'b0001},  // R8 between levels
    {12'b1110_0000_1100, 4'b1100},  // R8 cooled, restart
    {12'b1010_0000_1100, 4'b1100},  // R1 between supply levels, running
    {12'b1000_0000_1100, 4'b0001},  // R1 lockout engages
    {12'b1010_0000_1100, 4'b0001},  // R1 between levels, locked
    {12'b1110_0000_1100, 4'b1100},  // R1 release
    {12'b1110_0000_1101, 4'b0001},  // R9 overcurrent
    {12'b1110_0000_1100, 4'b0001},  // R9 held
    {12'b0110_0000_1100, 4'b0001},  // R9 enable low
    {12'b1110_0000_1100, 4'b1100}   // R10 restart
  };

  task automatic drive(input logic [11:0] v);
    {en, vr, vf, hi, lo, uv, ovp, th, tc, ssd, mov, oc} = v;
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {pg_ok, run, ls_force, ss_hold};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: outputs %b expected completion", {pg_ok, run, ls_force, ss_hold});
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    drive(12'b1110_0000_1100);
    repeat (3) @(negedge clk);
    check("R1 reset state", 4'b0001);
    rst_n = 1;
    foreach (VEC[k]) begin
      drive(VEC[k][15:4]);
      repeat (8) @(negedge clk);
      check($sformatf("R1-table step %0d", k), VEC[k][3:0]);
    end
    // R2: one-clock glitch on the undervoltage flag is rejected
    uv = 1; @(negedge clk); uv = 0;
    repeat (8) @(negedge clk);
    check("R2 glitch rejected", 4'b1100);
    // R2: one-clock enable drop does not stop the converter
    en = 0; @(negedge clk); en = 1;
    repeat (8) @(negedge clk);
    check("R2 enable glitch", 4'b1100);
    // R2: filter latency, run falls only after stages agree
    en = 0; @(negedge clk);
    check("R2 not yet filtered", 4'b1100);
    repeat (3) @(negedge clk);
    check("R2 filtered enable low", 4'b0001);
    en = 1; repeat (8) @(negedge clk);
    // R7: one clock response and release
    ovp = 1; @(negedge clk);
    check("R7 crowbar after one clock", 4'b1110);
    ovp = 0; @(negedge clk);
    check("R7 crowbar released", 4'b1100);
    // R9: lockout clears a latched fault
    oc = 1; @(negedge clk); oc = 0;
    repeat (2) @(negedge clk);
    check("R9 overcurrent latched", 4'b0001);
    vr = 0; vf = 0; repeat (8) @(negedge clk);
    vr = 1; vf = 1; repeat (8) @(negedge clk);
    check("R9 cleared by supply cycle", 4'b1100);
    // R6: undervoltage ignored before soft-start completes
    ssd = 0; uv = 1; repeat (8) @(negedge clk);
    check("R6 ignored during soft-start", 4'b0100);
    uv = 0; repeat (8) @(negedge clk);
    ssd = 1; @(negedge clk);
    check("R6 no latch left behind", 4'b1100);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule